// File: doc/BRIEF.md
# Chained Parallel Bus Controller

This controller joins one module to a short daisy-chained parallel bus that links a single master to as many as three slaves. The same RTL serves both roles. A reset parameter sets the role, and a bit in a small control register can change it later. The bus carries data words, one active-low write strobe, a shared request line, a poll line with a 3-bit address, a grant line, an acknowledge line and a done line. It has no arbitration wires.

A slave that wants a transfer picks the direction and the word count and then raises the shared request line. When the master sees that line, it polls the slave addresses in ascending order. The first slave that answers with its request flag set also returns the direction and the length of the transfer it wants. The master then grants the bus to that slave. The sender moves the words with a strobe of fixed timing. The receiver captures each word on the rising edge of the strobe, writes it into a local 16-word FIFO, and pulses done once the last word has arrived. While the bus is idle, the master drives the data lines.

Top module: `cbus_ctrl`

## Requirements
- R1: After reset, read data bits [2:0] hold the address parameter, bit 3 holds the role parameter (1 = master), bits [7:4] and [15:9] read 0, no request is raised, the receive FIFO is empty, and the master drives the data lines.
- R2: A control write is accepted only while the module is idle. It loads the address from write data [2:0] and the role from bit 3. Write bits [7:4] are discarded, and a write made while a request is pending leaves the register unchanged.
- R3: A slave idle start with a nonzero length raises the request line on the next cycle, and the line stays high until the slave sees a grant carrying its own address. A start with length 0 is ignored.
- R4: On a raised request, the master polls addresses 1, 2, ... up to NSLAVE in ascending order, holding each poll for 4 cycles. It stops at the first slave that acknowledges and does not poll any address after it.
- R5: A polled slave that is requesting answers with acknowledge high. It places its direction on data bit LENW (1 = the slave sends to the master) and its word count on bits [LENW-1:0]. The master adopts these values for the transfer.
- R6: Exactly the requested number of words is transferred. They are taken from the sender's transmit input in order and arrive in order at the receiver's FIFO.
- R7: Each word occupies 4 cycles. The data is launched 1 cycle before the strobe falls, the strobe stays low for exactly 2 cycles, and the data is unchanged from launch through the rising strobe edge.
- R8: The receiver asserts done for exactly one cycle, in the cycle after it captures the last word.
- R9: At most one module drives the data lines in any cycle, and the master drives them again no later than 2 cycles after done.
- R10: The receive FIFO holds 16 words. Read bit 8 and the memory interrupt output are high while it holds at least 8 words. A word that arrives while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Control write data: [2:0] address, [3] role |
| cfg_rdata_o | output | 16 | Control/status read: [2:0] address, [3] role, [8] FIFO half full |
| xfer_start_i | input | 1 | Slave: request a transfer |
| xfer_dir_i | input | 1 | Slave: 1 = send to master, 0 = receive from master |
| xfer_len_i | input | LENW | Slave: word count of the requested transfer |
| tx_data_i | input | DW | Next word to send |
| tx_pop_o | output | 1 | The word on tx_data_i has been taken |
| rx_pop_i | input | 1 | Remove the head word of the receive FIFO |
| rx_data_o | output | DW | Head word of the receive FIFO |
| rx_empty_o | output | 1 | Receive FIFO is empty |
| mem_irq_o | output | 1 | Receive FIFO at least half full |
| req_o | output | 1 | Slave request, ORed onto the shared line |
| req_i | input | 1 | Shared request line |
| poll_o | output | 1 | Master: poll cycle in progress |
| grant_o | output | 1 | Master: bus granted to the slave on addr_o |
| addr_o | output | 3 | Master: polled or granted slave address |
| poll_i | input | 1 | Slave: poll line from the master |
| grant_i | input | 1 | Slave: grant line from the master |
| addr_i | input | 3 | Slave: address lines from the master |
| ack_o | output | 1 | Slave: answer to a poll, equal to its request flag |
| ack_i | input | 1 | Master: shared acknowledge line |
| data_o | output | DW | Data word driven onto the bus |
| data_oe_o | output | 1 | This module drives the data lines |
| data_i | input | DW | Resolved data lines |
| stb_n_o | output | 1 | Active-low write strobe |
| stb_oe_o | output | 1 | This module drives the strobe |
| stb_n_i | input | 1 | Resolved strobe line, high when undriven |
| done_o | output | 1 | Receiver end-of-transfer pulse |
| done_i | input | 1 | Shared done line |

## Verification
The assertions rely on a few properties of the environment. Only one slave requests at a time. The bus lines reach every module in the same cycle, with the data and strobe resolved from the enable outputs. The transmit input always offers a word when one is taken. Under these conditions the poll, grant and strobe sequences are fully determined. The stimulus starts a new request only after the previous transfer has reported done and the bus has settled. It also keeps every length within LENW bits, so the single-requester and in-order assumptions are never broken.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_REQ,
        ST_SEND,
        ST_RECV,
        ST_WAIT
    } cbus_state_e;
endpackage

// File: rtl/cbus_strobe.sv
module cbus_strobe #(
    parameter int unsigned PERIOD    = 4,
    parameter int unsigned LOW_START = 2,
    parameter int unsigned LOW_LEN   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic ready_o,
    output logic load_o,
    output logic stb_n_o,
    output logic active_o
);
    localparam int unsigned CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        ready_o = (cnt_q == '0) || (cnt_q == CW'(PERIOD));
        load_o  = 1'b0;
        cnt_d   = cnt_q;
        if (ready_o) begin
            if (go_i) begin
                cnt_d  = CW'(1);
                load_o = 1'b1;
            end else begin
                cnt_d = '0;
            end
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign stb_n_o  = !((cnt_q >= CW'(LOW_START)) && (cnt_q < CW'(LOW_START + LOW_LEN)));
    assign active_o = (cnt_q != '0);

    p_stb_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(stb_n_o) |=> !stb_n_o);
    p_stb_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stb_n_o) |-> $past(!stb_n_o, 2));
endmodule

// File: rtl/cbus_fifo.sv
module cbus_fifo #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] dout_o,
    output logic          empty_o,
    output logic          half_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic full, do_push, do_pop;

    always_comb begin
        full    = (r_q.cnt == CW'(DEPTH));
        do_push = push_i && !full;
        do_pop  = pop_i && (r_q.cnt != '0);
        r_d     = r_q;
        if (do_push) r_d.wr = r_q.wr + AW'(1);
        if (do_pop)  r_d.rd = r_q.rd + AW'(1);
        r_d.cnt = r_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[r_q.wr] <= din_i;
    end

    assign dout_o  = mem_q[r_q.rd];
    assign empty_o = (r_q.cnt == '0);
    assign half_o  = (r_q.cnt >= CW'(DEPTH / 2));

    p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full && push_i && !pop_i) |=> (r_q.cnt == CW'(DEPTH)) && $stable(r_q.wr));
    p_half_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.cnt == CW'(DEPTH / 2 - 1) && push_i && !pop_i) |=> half_o);
endmodule

// File: rtl/cbus_ctrl.sv
module cbus_ctrl
    import cbus_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned LENW       = 4,
    parameter int unsigned NSLAVE     = 3,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter logic        RST_MASTER = 1'b0,
    parameter logic [2:0]  RST_ADDR   = 3'd0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_we_i,
    input  logic [7:0]      cfg_wdata_i,
    output logic [15:0]     cfg_rdata_o,
    input  logic            xfer_start_i,
    input  logic            xfer_dir_i,
    input  logic [LENW-1:0] xfer_len_i,
    input  logic [DW-1:0]   tx_data_i,
    output logic            tx_pop_o,
    input  logic            rx_pop_i,
    output logic [DW-1:0]   rx_data_o,
    output logic            rx_empty_o,
    output logic            mem_irq_o,
    output logic            req_o,
    input  logic            req_i,
    output logic            poll_o,
    output logic            grant_o,
    output logic [2:0]      addr_o,
    input  logic            poll_i,
    input  logic            grant_i,
    input  logic [2:0]      addr_i,
    output logic            ack_o,
    input  logic            ack_i,
    output logic [DW-1:0]   data_o,
    output logic            data_oe_o,
    input  logic [DW-1:0]   data_i,
    output logic            stb_n_o,
    output logic            stb_oe_o,
    input  logic            stb_n_i,
    output logic            done_o,
    input  logic            done_i
);
    localparam logic [1:0] POLL_LAST = 2'd3;

    typedef struct packed {
        cbus_state_e       st;
        logic [ADDR_W-1:0] idx;
        logic [1:0]        pcnt;
        logic              dir;
        logic [LENW-1:0]   len;
        logic [LENW-1:0]   left;
        logic [DW-1:0]     dat;
        logic              stb_prev;
        logic              done;
        logic              resp;
        logic [ADDR_W-1:0] addr;
        logic              master;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic go, stb_ready, stb_load, stb_act, push, rise, half;

    always_comb begin
        r_d          = r_q;
        push         = 1'b0;
        go           = (r_q.st == ST_SEND) && (r_q.left != '0);
        rise         = !r_q.stb_prev && stb_n_i;
        r_d.stb_prev = stb_n_i;
        r_d.done     = 1'b0;
        r_d.resp     = !r_q.master && (r_q.st == ST_REQ) && poll_i && (addr_i == r_q.addr);
        case (r_q.st)
            ST_IDLE: begin
                if (cfg_we_i) begin
                    r_d.addr   = cfg_wdata_i[2:0];
                    r_d.master = cfg_wdata_i[3];
                end else if (r_q.master && req_i) begin
                    r_d.st   = ST_POLL;
                    r_d.idx  = ADDR_W'(1);
                    r_d.pcnt = '0;
                end else if (!r_q.master && xfer_start_i && (xfer_len_i != '0)) begin
                    r_d.st  = ST_REQ;
                    r_d.dir = xfer_dir_i;
                    r_d.len = xfer_len_i;
                end
            end
            ST_POLL: begin
                r_d.pcnt = r_q.pcnt + 2'd1;
                if (r_q.pcnt == POLL_LAST) begin
                    if (ack_i) begin
                        r_d.dir  = data_i[LENW];
                        r_d.len  = data_i[LENW-1:0];
                        r_d.left = data_i[LENW-1:0];
                        r_d.st   = data_i[LENW] ? ST_RECV : ST_SEND;
                    end else if (r_q.idx == ADDR_W'(NSLAVE)) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + ADDR_W'(1);
                    end
                end
            end
            ST_REQ: begin
                if (grant_i && (addr_i == r_q.addr)) begin
                    r_d.st   = r_q.dir ? ST_SEND : ST_RECV;
                    r_d.left = r_q.len;
                end
            end
            ST_SEND: begin
                if (stb_load) begin
                    r_d.dat  = tx_data_i;
                    r_d.left = r_q.left - LENW'(1);
                end
                if ((r_q.left == '0) && stb_ready) r_d.st = ST_WAIT;
            end
            ST_RECV: begin
                if (rise) begin
                    push     = 1'b1;
                    r_d.left = r_q.left - LENW'(1);
                    if (r_q.left == LENW'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (done_i) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.stb_prev <= 1'b1;
            r_q.addr     <= RST_ADDR;
            r_q.master   <= RST_MASTER;
        end else begin
            r_q <= r_d;
        end
    end

    cbus_strobe #(.PERIOD(4), .LOW_START(2), .LOW_LEN(2)) u_strobe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .go_i     (go),
        .ready_o  (stb_ready),
        .load_o   (stb_load),
        .stb_n_o  (stb_n_o),
        .active_o (stb_act)
    );

    cbus_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .din_i   (data_i),
        .pop_i   (rx_pop_i),
        .dout_o  (rx_data_o),
        .empty_o (rx_empty_o),
        .half_o  (half)
    );

    assign tx_pop_o    = stb_load;
    assign mem_irq_o   = half;
    assign cfg_rdata_o = {7'b0, half, 4'b0, r_q.master, r_q.addr};
    assign req_o       = !r_q.master && (r_q.st == ST_REQ);
    assign poll_o      = r_q.master && (r_q.st == ST_POLL);
    assign grant_o     = r_q.master && ((r_q.st == ST_SEND) || (r_q.st == ST_RECV) || (r_q.st == ST_WAIT));
    assign addr_o      = r_q.idx;
    assign ack_o       = r_q.resp;
    assign data_o      = r_q.resp ? DW'({r_q.dir, r_q.len}) : r_q.dat;
    assign data_oe_o   = r_q.master ? ((r_q.st == ST_IDLE) || (r_q.st == ST_WAIT) || ((r_q.st == ST_SEND) && stb_act))
                                    : (r_q.resp || ((r_q.st == ST_SEND) && stb_act));
    assign stb_oe_o    = (r_q.st == ST_SEND) && stb_act;
    assign done_o      = r_q.done;

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_req_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && grant_i && (addr_i == r_q.addr)) |=> !req_o);
    p_zero_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!r_q.master && (r_q.st == ST_IDLE) && !cfg_we_i && xfer_start_i && (xfer_len_i == '0)) |=> !req_o);
    p_poll_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (poll_o && $past(poll_o) && (addr_o != $past(addr_o))) |-> (addr_o == $past(addr_o) + 3'd1));
    p_master_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.master && (r_q.st == ST_WAIT) && done_i) |=> data_oe_o);
endmodule

// File: tb/cbus_ctrl_tb_top.sv
module cbus_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;

    logic        cfg_we [4];
    logic [7:0]  cfg_wd [4];
    logic [15:0] cfg_rd [4];
    logic        start [4];
    logic        sdir [4];
    logic [3:0]  slen [4];
    logic [15:0] txd [4];
    logic        txpop [4];
    logic        rxpop [4];
    logic [15:0] rxd [4];
    logic        rxe [4];
    logic        mirq [4];
    logic        req [4];
    logic        poll [4];
    logic        grant [4];
    logic [2:0]  ao [4];
    logic        ack [4];
    logic [15:0] dout [4];
    logic        doe [4];
    logic        stbo [4];
    logic        stboe [4];
    logic        done [4];
    logic [15:0] txcnt [4];

    logic        req_bus, ack_bus, done_bus, stb_bus;
    logic [15:0] data_bus;
    int          n_oe;

    always_comb begin
        req_bus = 1'b0; ack_bus = 1'b0; done_bus = 1'b0; stb_bus = 1'b1;
        data_bus = '0; n_oe = 0;
        for (int i = 0; i < 4; i++) begin
            req_bus  = req_bus | req[i];
            ack_bus  = ack_bus | ack[i];
            done_bus = done_bus | done[i];
            if (stboe[i] && !stbo[i]) stb_bus = 1'b0;
            if (doe[i]) begin
                data_bus = data_bus | dout[i];
                n_oe = n_oe + 1;
            end
            txd[i] = 16'((i + 1) * 16'h1000) + txcnt[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (!rst_n)        txcnt[i] <= '0;
            else if (txpop[i]) txcnt[i] <= txcnt[i] + 16'd1;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_mod
        cbus_ctrl #(.RST_MASTER(g == 0), .RST_ADDR(3'(g))) dut_i (
            .clk_i(clk), .rst_ni(rst_n),
            .cfg_we_i(cfg_we[g]), .cfg_wdata_i(cfg_wd[g]), .cfg_rdata_o(cfg_rd[g]),
            .xfer_start_i(start[g]), .xfer_dir_i(sdir[g]), .xfer_len_i(slen[g]),
            .tx_data_i(txd[g]), .tx_pop_o(txpop[g]),
            .rx_pop_i(rxpop[g]), .rx_data_o(rxd[g]), .rx_empty_o(rxe[g]), .mem_irq_o(mirq[g]),
            .req_o(req[g]), .req_i(req_bus),
            .poll_o(poll[g]), .grant_o(grant[g]), .addr_o(ao[g]),
            .poll_i(poll[0]), .grant_i(grant[0]), .addr_i(ao[0]),
            .ack_o(ack[g]), .ack_i(ack_bus),
            .data_o(dout[g]), .data_oe_o(doe[g]), .data_i(data_bus),
            .stb_n_o(stbo[g]), .stb_oe_o(stboe[g]), .stb_n_i(stb_bus),
            .done_o(done[g]), .done_i(done_bus)
        );
    end

    // bus monitor
    int contention = 0, stb_err = 0, done_err = 0, oe_err = 0;
    int rises = 0, exp_len = 0, done_seen = 0, since_rise = 100, low_cnt = 0, back_cnt = 0;
    int nlog = 0;
    logic [2:0]  plog [8];
    logic        prev_stb = 1'b1, prev_done = 1'b0, prev_rise = 1'b0, prev_poll = 1'b0;
    logic [2:0]  prev_ao = '0;
    logic [15:0] prev_data = '0, held = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (n_oe > 1) contention++;
            if (since_rise < 100) since_rise++;
            if (!stb_bus) begin
                if (prev_stb) begin
                    held = data_bus;
                    low_cnt = 1;
                    if (data_bus != prev_data) stb_err++;
                end else begin
                    low_cnt++;
                    if (data_bus != held) stb_err++;
                end
            end
            if (stb_bus && !prev_stb) begin
                if (low_cnt != 2 || data_bus != held) stb_err++;
                if (since_rise < 8 && since_rise != 4) stb_err++;
                since_rise = 0;
                rises++;
            end
            if (back_cnt > 0) begin
                back_cnt++;
                if (back_cnt == 3) begin
                    if (!doe[0]) oe_err++;
                    back_cnt = 0;
                end
            end
            if (done_bus) begin
                if (prev_done || !prev_rise || rises != exp_len) done_err++;
                done_seen++;
                back_cnt = 1;
            end
            if (poll[0] && (!prev_poll || ao[0] != prev_ao) && nlog < 8) begin
                plog[nlog] = ao[0];
                nlog++;
            end
            prev_rise = stb_bus && !prev_stb;
            prev_stb  = stb_bus;
            prev_done = done_bus;
            prev_poll = poll[0];
            prev_ao   = ao[0];
            prev_data = data_bus;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_clean(input string tag);
        chk(contention == 0, {tag, " R9 contention"}, contention, 0);
        chk(stb_err == 0, {tag, " R7 strobe"}, stb_err, 0);
        chk(done_err == 0, {tag, " R8 done"}, done_err, 0);
        chk(oe_err == 0, {tag, " R9 master back"}, oe_err, 0);
    endtask

    task automatic wait_done();
        for (int t = 0; t < 600 && done_seen == 0; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_xfer(input int src, input bit d, input int len);
        exp_len = len; rises = 0; done_seen = 0; nlog = 0;
        @(negedge clk);
        start[src] = 1'b1; sdir[src] = d; slen[src] = 4'(len);
        @(negedge clk);
        start[src] = 1'b0;
        chk(req[src] == 1'b1, "R3 request raised", req[src], 1);
        wait_done();
        chk(done_seen == 1, "R8 one done pulse", done_seen, 1);
        chk(req_bus == 1'b0, "R3 request cleared", req_bus, 0);
    endtask

    task automatic drain(input int inst, input int n, input logic [15:0] first, input string tag);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(!rxe[inst] && rxd[inst] == first + 16'(j), tag, rxd[inst], first + 16'(j));
            rxpop[inst] = 1'b1;
            @(negedge clk);
            rxpop[inst] = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(cfg_rd[0] == 16'h0008, "R1 master cfg", cfg_rd[0], 16'h0008);
        chk(cfg_rd[2] == 16'h0002, "R1 slave cfg", cfg_rd[2], 16'h0002);
        chk(doe[0] == 1'b1 && n_oe == 1, "R1 master drives idle bus", n_oe, 1);
        chk(req_bus == 1'b0, "R1 no request", req_bus, 0);
        chk(rxe[0] && rxe[1] && rxe[2] && rxe[3], "R1 fifo empty", rxe[0], 1);
    endtask

    task automatic t_slave_send();
        logic [15:0] s0 = txcnt[2];
        do_xfer(2, 1'b1, 5);
        chk(nlog == 2 && plog[0] == 3'd1 && plog[1] == 3'd2, "R4 poll 1,2 then stop", nlog, 2);
        drain(0, 5, 16'h3000 + s0, "R6 R5 slave2->master word");
        bus_clean("slave send");
    endtask

    task automatic t_master_send();
        logic [15:0] s0 = txcnt[0];
        do_xfer(3, 1'b0, 3);
        chk(nlog == 3 && plog[2] == 3'd3, "R4 poll up to 3", nlog, 3);
        chk(rxe[0], "R6 master fifo untouched", rxe[0], 1);
        drain(3, 3, 16'h1000 + s0, "R6 R5 master->slave3 word");
        bus_clean("master send");
    endtask

    task automatic t_zero_len();
        @(negedge clk);
        start[1] = 1'b1; sdir[1] = 1'b1; slen[1] = 4'd0;
        @(negedge clk);
        start[1] = 1'b0;
        repeat (10) @(negedge clk);
        chk(req_bus == 1'b0 && !poll[0], "R3 zero length ignored", req_bus, 0);
        chk(rxe[0], "R3 nothing transferred", rxe[0], 1);
    endtask

    task automatic t_cfg();
        logic [15:0] s0;
        @(negedge clk);
        cfg_we[2] = 1'b1; cfg_wd[2] = 8'hF2;
        @(negedge clk);
        cfg_we[2] = 1'b0;
        chk(cfg_rd[2] == 16'h0002, "R2 reserved bits dropped", cfg_rd[2], 16'h0002);
        s0 = txcnt[2];
        exp_len = 1; rises = 0; done_seen = 0; nlog = 0;
        start[2] = 1'b1; sdir[2] = 1'b1; slen[2] = 4'd1;
        @(negedge clk);
        start[2] = 1'b0; cfg_we[2] = 1'b1; cfg_wd[2] = 8'h05;
        @(negedge clk);
        cfg_we[2] = 1'b0;
        wait_done();
        chk(cfg_rd[2] == 16'h0002, "R2 busy write ignored", cfg_rd[2], 16'h0002);
        drain(0, 1, 16'h3000 + s0, "R2 transfer after busy write");
    endtask

    task automatic t_fifo();
        logic [15:0] s0 = txcnt[1];
        do_xfer(1, 1'b1, 9);
        chk(nlog == 1, "R4 stop at first", nlog, 1);
        chk(mirq[0] == 1'b1 && cfg_rd[0][8], "R10 half full at 9", cfg_rd[0], 16'h0108);
        drain(0, 2, 16'h2000 + s0, "R10 word");
        chk(mirq[0] == 1'b0 && !cfg_rd[0][8], "R10 below half at 7", cfg_rd[0], 16'h0008);
        drain(0, 7, 16'h2000 + s0 + 16'd2, "R10 word");
        s0 = txcnt[1];
        do_xfer(1, 1'b1, 15);
        do_xfer(1, 1'b1, 3);
        drain(0, 16, 16'h2000 + s0, "R10 full fifo word");
        @(negedge clk);
        chk(rxe[0], "R10 extra words dropped", rxe[0], 1);
        bus_clean("fifo");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            cfg_we[i] = 1'b0; cfg_wd[i] = '0; start[i] = 1'b0;
            sdir[i] = 1'b0; slen[i] = '0; rxpop[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slave_send();
        t_master_send();
        t_zero_len();
        t_cfg();
        t_fifo();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule